// File: doc/BRIEF.md
# Guarded Error Record Register Bank

This block holds a single error record for a reliability-reporting unit. Hardware error reports arrive on a capture port. The first report into an empty record latches a syndrome, a type flag (uncorrectable or correctable), a block of extra information and an optional faulting address. Any later report that arrives while the record is still valid raises an overflow flag and leaves the first report's data in place. Two miscellaneous registers each carry a saturating error counter in their low byte. The first counts every report. The second counts only uncorrectable reports.

Software inspects the record through a simple single-cycle register port. It then releases the record by writing ones to the status flags. The clear is guarded so that a report landing in the middle of software handling cannot be lost silently. A flag-type clear is refused while overflow stays set. A clear of the remaining status fields is refused while a type flag stays set. Logged information and the logged address are write-protected while their valid flags are set. A capture and a clear of the same bit in the same cycle resolve in favour of the capture.

Top module: `err_record_bank`

## Requirements
- R1: After reset, all four registers read zero. Register select values are: 0 status, 1 misc A, 2 misc B, 3 address.
- R2: A capture into an empty record (valid flag clear) has the following effect, visible on the cycle after the capture. Status bit0 (valid) and bit4 (misc-valid) are set. Bit1 (uncorrectable) is set when `cap_uncorr` is high; otherwise bit2 (correctable) is set. Bits [15:8] take the syndrome. Misc A bits [31:8] take `cap_info`. When `cap_addr_valid` is high, bit5 (address-valid) is set and the address register takes `cap_addr`.
- R3: A capture into a valid record sets status bit3 (overflow) and ORs in its own type flag. The syndrome, misc A information and address keep the values of the first report.
- R4: Misc A bits [7:0] count every capture. Misc B bits [7:0] count uncorrectable captures. Both counters saturate at 255.
- R5: A status write treats bits [5:0] as a write-1-to-clear mask. Writing 0 to a bit leaves it unchanged. Clearing the valid flag also zeroes the syndrome.
- R6: A write to bit1 or bit2 of status has no effect while overflow is set, unless the same write has bit3 set.
- R7: A write to bit0, bit3, bit4 or bit5 of status has no effect while bit1 or bit2 remains set after that same write.
- R8: While misc-valid is set, writes to bits [31:8] of misc A and misc B are ignored. Bits [7:0] of both registers are always writable.
- R9: While address-valid is set, writes to the address register are ignored.
- R10: When a capture and a software write land in the same cycle, the write is applied first and the capture second. Flags set by the capture therefore survive, and a record emptied by the write takes the capture as a fresh first report.
- R11: Reads are combinational and have no side effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cap_valid | input | 1 | Hardware error report strobe |
| cap_uncorr | input | 1 | Report is uncorrectable (else correctable) |
| cap_syndrome | input | SYN_W | Syndrome of the report |
| cap_info | input | DATA_W-CNT_W | Extra information for misc A |
| cap_addr_valid | input | 1 | Report carries an address |
| cap_addr | input | ADDR_W | Faulting address |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 2 | Register selected for write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register selected for read |
| rd_data | output | DATA_W | Read data of the selected register |

## Verification
The bench sets overflow, then tries to clear a type flag without also clearing overflow. A design that ignored the guard would drop the record of the first error. It also tries to release the valid, misc-valid and address-valid flags while a type flag stays set. A design that allowed this would reopen the record with stale type flags. It writes the locked information and address fields, and it drives a capture and a full clear in the same cycle. A design that let the write win there would lose the new report. Counter saturation is driven from 254 upward to catch wrap-around to zero. A long random phase is compared against a behavioural model on every clock.

// File: rtl/err_rec_pkg.sv
`timescale 1ns/1ps
package err_rec_pkg;

  // status bit positions (software decodes these)
  localparam int unsigned F_V      = 0;
  localparam int unsigned F_UE     = 1;
  localparam int unsigned F_CE     = 2;
  localparam int unsigned F_OF     = 3;
  localparam int unsigned F_MV     = 4;
  localparam int unsigned F_AV     = 5;
  localparam int unsigned FLAG_N   = 6;
  localparam int unsigned SYN_LSB  = 8;

  typedef struct packed {
    logic av;
    logic mv;
    logic of;
    logic ce;
    logic ue;
    logic v;
  } flags_t;

  typedef enum logic [1:0] {
    SEL_STAT   = 2'd0,
    SEL_MISC_A = 2'd1,
    SEL_MISC_B = 2'd2,
    SEL_ADDR   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/err_rst_sync.sv
`timescale 1ns/1ps
module err_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/err_status_ctrl.sv
`timescale 1ns/1ps
module err_status_ctrl
  import err_rec_pkg::*;
#(
  parameter int unsigned SYN_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_valid,
  input  logic                cap_uncorr,
  input  logic                cap_addr_valid,
  input  logic [SYN_W-1:0]    cap_syndrome,
  input  logic                stat_wr,
  input  logic [FLAG_N-1:0]   clr_bits,
  output flags_t              flags_q,
  output logic [SYN_W-1:0]    syn_q,
  output logic                cap_fresh
);

  flags_t           clr;
  flags_t           mid;
  flags_t           flags_d;
  logic [SYN_W-1:0] syn_mid;
  logic [SYN_W-1:0] syn_d;
  logic             type_ok;
  logic             other_ok;
  logic             stat_en;

  // software clear stage
  always_comb begin
    clr = stat_wr ? flags_t'(clr_bits) : '0;

    // type flags move only if overflow is clear or cleared in this write
    type_ok = !flags_q.of || clr.of;
    mid.ue  = flags_q.ue && !(type_ok && clr.ue);
    mid.ce  = flags_q.ce && !(type_ok && clr.ce);

    // remaining fields move only when no type flag survives the write
    other_ok = !mid.ue && !mid.ce;
    mid.v    = flags_q.v  && !(other_ok && clr.v);
    mid.of   = flags_q.of && !(other_ok && clr.of);
    mid.mv   = flags_q.mv && !(other_ok && clr.mv);
    mid.av   = flags_q.av && !(other_ok && clr.av);

    syn_mid  = mid.v ? syn_q : '0;
  end

  // hardware capture stage, applied on top of the clear
  always_comb begin
    flags_d   = mid;
    syn_d     = syn_mid;
    cap_fresh = cap_valid && !mid.v;
    if (cap_valid) begin
      flags_d.v  = 1'b1;
      flags_d.mv = 1'b1;
      flags_d.ue = mid.ue || cap_uncorr;
      flags_d.ce = mid.ce || !cap_uncorr;
      flags_d.of = mid.of || mid.v;
      flags_d.av = mid.av || cap_addr_valid;
      if (!mid.v) syn_d = cap_syndrome;
    end
    stat_en = cap_valid || stat_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      syn_q   <= '0;
    end else if (stat_en) begin
      flags_q <= flags_d;
      syn_q   <= syn_d;
    end
  end

endmodule

// File: rtl/err_misc_reg.sv
`timescale 1ns/1ps
module err_misc_reg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned INFO_W = DATA_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              lock,
  input  logic              cnt_inc,
  input  logic              info_load,
  input  logic [INFO_W-1:0] info_in,
  output logic [DATA_W-1:0] q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_base;
  logic [CNT_W-1:0]  cnt_d;
  logic [INFO_W-1:0] info_q;
  logic [INFO_W-1:0] info_d;
  logic              cnt_en;
  logic              info_en;

  always_comb begin
    cnt_base = sw_wr ? sw_data[CNT_W-1:0] : cnt_q;
    cnt_d    = cnt_base;
    if (cnt_inc && (cnt_base != CNT_MAX)) cnt_d = cnt_base + 1'b1;
    cnt_en   = sw_wr || cnt_inc;

    info_d   = info_q;
    info_en  = 1'b0;
    if (info_load) begin
      info_d  = info_in;
      info_en = 1'b1;
    end else if (sw_wr && !lock) begin
      info_d  = sw_data[DATA_W-1:CNT_W];
      info_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       info_q <= '0;
    else if (info_en) info_q <= info_d;
  end

  assign q = {info_q, cnt_q};

endmodule

// File: rtl/err_addr_reg.sv
`timescale 1ns/1ps
module err_addr_reg #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [ADDR_W-1:0] sw_data,
  input  logic              lock,
  input  logic              hw_load,
  input  logic [ADDR_W-1:0] hw_addr,
  output logic [ADDR_W-1:0] q
);

  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_d  = q;
    addr_en = 1'b0;
    if (hw_load) begin
      addr_d  = hw_addr;
      addr_en = 1'b1;
    end else if (sw_wr && !lock) begin
      addr_d  = sw_data;
      addr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (addr_en) q <= addr_d;
  end

endmodule

// File: rtl/err_record_bank.sv
`timescale 1ns/1ps
module err_record_bank
  import err_rec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap_valid,
  input  logic                     cap_uncorr,
  input  logic [SYN_W-1:0]         cap_syndrome,
  input  logic [DATA_W-CNT_W-1:0]  cap_info,
  input  logic                     cap_addr_valid,
  input  logic [ADDR_W-1:0]        cap_addr,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [1:0]               rd_sel,
  output logic [DATA_W-1:0]        rd_data
);

  localparam int unsigned MISC_N = 2;

  logic              rst_n_int;
  flags_t            flags_q;
  logic [SYN_W-1:0]  syn_q;
  logic              cap_fresh;
  logic              stat_wr;
  logic              addr_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [MISC_N-1:0] misc_wr;
  logic [MISC_N-1:0] misc_inc;
  logic [MISC_N-1:0] misc_load;
  logic [DATA_W-1:0] misc_q [MISC_N];

  // flat views used by the bound checker
  logic              v_q, ue_q, ce_q, of_q, mv_q, av_q;
  logic [DATA_W-1:0] misc_a_q;

  err_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  assign stat_wr = wr_en && (wr_sel == SEL_STAT);
  assign addr_wr = wr_en && (wr_sel == SEL_ADDR);

  err_status_ctrl #(.SYN_W(SYN_W)) u_stat (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .cap_valid      (cap_valid),
    .cap_uncorr     (cap_uncorr),
    .cap_addr_valid (cap_addr_valid),
    .cap_syndrome   (cap_syndrome),
    .stat_wr        (stat_wr),
    .clr_bits       (wr_data[FLAG_N-1:0]),
    .flags_q        (flags_q),
    .syn_q          (syn_q),
    .cap_fresh      (cap_fresh)
  );

  // misc A counts all reports and logs info; misc B counts uncorrectable only
  assign misc_inc[0]  = cap_valid;
  assign misc_inc[1]  = cap_valid && cap_uncorr;
  assign misc_load[0] = cap_fresh;
  assign misc_load[1] = 1'b0;

  for (genvar gi = 0; gi < MISC_N; gi++) begin : g_misc
    assign misc_wr[gi] = wr_en && (wr_sel == 2'(gi + 1));
    err_misc_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_misc (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .sw_wr     (misc_wr[gi]),
      .sw_data   (wr_data),
      .lock      (flags_q.mv),
      .cnt_inc   (misc_inc[gi]),
      .info_load (misc_load[gi]),
      .info_in   (cap_info),
      .q         (misc_q[gi])
    );
  end

  err_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .sw_wr   (addr_wr),
    .sw_data (wr_data[ADDR_W-1:0]),
    .lock    (flags_q.av),
    .hw_load (cap_fresh && cap_addr_valid),
    .hw_addr (cap_addr),
    .q       (addr_q)
  );

  always_comb begin
    rd_data = '0;
    case (reg_sel_e'(rd_sel))
      SEL_STAT: begin
        rd_data[FLAG_N-1:0]         = flags_q;
        rd_data[SYN_LSB +: SYN_W]   = syn_q;
      end
      SEL_MISC_A: rd_data = misc_q[0];
      SEL_MISC_B: rd_data = misc_q[1];
      default:    rd_data[ADDR_W-1:0] = addr_q;
    endcase
  end

  assign v_q      = flags_q.v;
  assign ue_q     = flags_q.ue;
  assign ce_q     = flags_q.ce;
  assign of_q     = flags_q.of;
  assign mv_q     = flags_q.mv;
  assign av_q     = flags_q.av;
  assign misc_a_q = misc_q[0];

endmodule

// File: rtl/err_record_chk.sv
`timescale 1ns/1ps
module err_record_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_valid,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [5:0]        clr_bits,
  input logic              v_q,
  input logic              ue_q,
  input logic              ce_q,
  input logic              of_q,
  input logic              mv_q,
  input logic              av_q,
  input logic [SYN_W-1:0]  syn_q,
  input logic [DATA_W-1:0] misc_a_q,
  input logic [ADDR_W-1:0] addr_q
);

  assert_cap_sets_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> (v_q && mv_q));

  assert_cap_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && v_q && !wr_en) |=> of_q);

  assert_syn_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !(wr_en && wr_sel == 2'd0)) |=> $stable(syn_q));

  assert_cnt_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd1) |=> (misc_a_q[CNT_W-1:0] >= $past(misc_a_q[CNT_W-1:0])));

  assert_type_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (of_q && wr_en && wr_sel == 2'd0 && !clr_bits[3] && !cap_valid)
      |=> ($stable(ue_q) && $stable(ce_q)));

  assert_other_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_q && wr_en && wr_sel == 2'd0 && !clr_bits[1] && !cap_valid)
      |=> ($stable(v_q) && $stable(of_q) && $stable(mv_q) && $stable(av_q)));

  assert_info_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_q && wr_en && wr_sel == 2'd1 && !cap_valid)
      |=> $stable(misc_a_q[DATA_W-1:CNT_W]));

  assert_addr_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (av_q && wr_en && wr_sel == 2'd3 && !cap_valid) |=> $stable(addr_q));

endmodule

bind err_record_bank err_record_chk #(
  .DATA_W (DATA_W),
  .SYN_W  (SYN_W),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_int),
  .cap_valid (cap_valid),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .clr_bits  (wr_data[5:0]),
  .v_q       (v_q),
  .ue_q      (ue_q),
  .ce_q      (ce_q),
  .of_q      (of_q),
  .mv_q      (mv_q),
  .av_q      (av_q),
  .syn_q     (syn_q),
  .misc_a_q  (misc_a_q),
  .addr_q    (addr_q)
);

// File: tb/sim_err_record_bank.sv
`timescale 1ns/1ps
module sim_err_record_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0, cap_uncorr = 1'b0, cap_addr_valid = 1'b0;
  logic [7:0]  cap_syndrome = '0;
  logic [23:0] cap_info = '0;
  logic [31:0] cap_addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 0;
  logic [31:0] snap [4];

  always #2.5 clk = ~clk;

  err_record_bank u0 (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_uncorr(cap_uncorr),
    .cap_syndrome(cap_syndrome), .cap_info(cap_info), .cap_addr_valid(cap_addr_valid),
    .cap_addr(cap_addr), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  bit m_v, m_ue, m_ce, m_of, m_mv, m_av;
  int m_syn, m_infoA, m_infoB, m_cntA, m_cntB;
  logic [31:0] m_addr;
  bit ok_type, l_ue, l_ce, ok_oth, l_v, l_of, l_mv, l_av;
  logic [5:0] clrm;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_v, m_ue, m_ce, m_of, m_mv, m_av} = '0;
      m_syn = 0; m_infoA = 0; m_infoB = 0; m_cntA = 0; m_cntB = 0; m_addr = 0;
    end else begin
      clrm = (wr_en && wr_sel == 0) ? wr_data[5:0] : 6'd0;
      ok_type = !m_of || clrm[3];
      l_ue = m_ue && !(ok_type && clrm[1]);
      l_ce = m_ce && !(ok_type && clrm[2]);
      ok_oth = !l_ue && !l_ce;
      l_v  = m_v  && !(ok_oth && clrm[0]);
      l_of = m_of && !(ok_oth && clrm[3]);
      l_mv = m_mv && !(ok_oth && clrm[4]);
      l_av = m_av && !(ok_oth && clrm[5]);
      if (!l_v) m_syn = 0;
      if (wr_en && wr_sel == 1) begin
        m_cntA = wr_data[7:0];
        if (!m_mv) m_infoA = wr_data[31:8];
      end
      if (wr_en && wr_sel == 2) begin
        m_cntB = wr_data[7:0];
        if (!m_mv) m_infoB = wr_data[31:8];
      end
      if (wr_en && wr_sel == 3 && !m_av) m_addr = wr_data;
      m_v = l_v; m_ue = l_ue; m_ce = l_ce; m_of = l_of; m_mv = l_mv; m_av = l_av;
      if (cap_valid) begin
        if (m_cntA < 255) m_cntA++;
        if (cap_uncorr && m_cntB < 255) m_cntB++;
        if (!l_v) begin
          m_syn = cap_syndrome;
          m_infoA = cap_info;
          if (cap_addr_valid) m_addr = cap_addr;
        end
        m_of = l_of || l_v;
        m_v = 1; m_mv = 1;
        if (cap_uncorr) m_ue = 1; else m_ce = 1;
        if (cap_addr_valid) m_av = 1;
      end
    end
  end

  function automatic logic [31:0] model_reg(int s);
    case (s)
      0: return {16'd0, 8'(m_syn), 2'b00, m_av, m_mv, m_of, m_ce, m_ue, m_v};
      1: return {24'(m_infoA), 8'(m_cntA)};
      2: return {24'(m_infoB), 8'(m_cntB)};
      default: return m_addr;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h @%0t", req, got, exp, $time);
    end
  endtask

  // per-clock comparison of all registers (read port is free of side effects, R11)
  always @(posedge clk) begin
    #1;
    for (int s = 0; s < 4; s++) begin
      rd_sel = 2'(s);
      #0.2;
      snap[s] = rd_data;
      if (mon_on)
        check(s == 0 ? "R5 status vs model" : (s == 3 ? "R9 address vs model" : "R4 misc vs model"),
              rd_data, model_reg(s));
    end
  end

  task automatic drive(bit cv, bit cu, logic [7:0] syn, logic [23:0] info, bit cav,
                       logic [31:0] ca, bit we, logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cap_valid = cv; cap_uncorr = cu; cap_syndrome = syn; cap_info = info;
    cap_addr_valid = cav; cap_addr = ca; wr_en = we; wr_sel = sel; wr_data = d;
    @(negedge clk);
    cap_valid = 0; cap_uncorr = 0; cap_addr_valid = 0; wr_en = 0;
  endtask

  task automatic cap(bit cu, logic [7:0] syn, logic [23:0] info, bit cav, logic [31:0] ca);
    drive(1, cu, syn, info, cav, ca, 0, 0, 0);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    drive(0, 0, 0, 0, 0, 0, 1, sel, d);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    mon_on = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) check("R1 reset value", snap[s], 32'h0);

    cap(0, 8'h5A, 24'h123456, 1, 32'hDEADBEEF);
    check("R2 status after first capture", snap[0], 32'h5A35);
    check("R2 misc A info and count", snap[1], 32'h12345601);
    check("R2 address captured", snap[3], 32'hDEADBEEF);

    cap(1, 8'h77, 24'hABCDEF, 1, 32'h11111111);
    check("R3 overflow with first syndrome", snap[0], 32'h5A3F);
    check("R3 misc A keeps first info", snap[1], 32'h12345602);
    check("R4 misc B counts uncorrectable", snap[2], 32'h00000001);
    check("R3 address keeps first", snap[3], 32'hDEADBEEF);

    wr(0, 32'h2);
    check("R6 type clear refused under overflow", snap[0], 32'h5A3F);
    wr(0, 32'h1);
    check("R7 valid clear refused under type flags", snap[0], 32'h5A3F);

    wr(1, 32'hFFFFFF05);
    check("R8 misc A info locked, count written", snap[1], 32'h12345605);
    wr(2, 32'hAAAAAA00);
    check("R8 misc B info locked", snap[2], 32'h00000000);
    wr(3, 32'h0);
    check("R9 address locked", snap[3], 32'hDEADBEEF);

    wr(0, 32'h3F);
    check("R5 full clear zeroes status", snap[0], 32'h0);

    wr(1, 32'hFFFFFF05);
    check("R8 misc A writable when unlocked", snap[1], 32'hFFFFFF05);
    wr(3, 32'h12345678);
    check("R9 address writable when unlocked", snap[3], 32'h12345678);

    cap(0, 8'h11, 24'h000042, 0, 32'h0);
    check("R2 capture without address", snap[0], 32'h1115);
    check("R2 address untouched", snap[3], 32'h12345678);

    drive(1, 1, 8'h22, 24'h000099, 1, 32'hCAFEF00D, 1, 0, 32'h3F);
    check("R10 capture wins over clear", snap[0], 32'h2233);
    check("R10 fresh info and count", snap[1], 32'h00009907);
    check("R10 fresh address", snap[3], 32'hCAFEF00D);

    wr(0, 32'h30);
    check("R7 flag clear refused while UE stays", snap[0], 32'h2233);
    wr(0, 32'h02);
    check("R5 UE cleared alone", snap[0], 32'h2231);
    wr(0, 32'h30);
    check("R7 MV/AV clear allowed once type flags gone", snap[0], 32'h2201);
    wr(0, 32'h01);
    check("R5 valid clear zeroes syndrome", snap[0], 32'h0);

    wr(1, 32'h000000FE);
    cap(0, 8'h33, 24'h0, 0, 32'h0);
    cap(0, 8'h44, 24'h5, 0, 32'h0);
    check("R4 counter saturates at 255", snap[1], 32'h000000FF);
    repeat (3) @(negedge clk);
    check("R11 reads leave status intact", snap[0], 32'h331D);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      cap_valid      = ($urandom_range(3) == 0);
      cap_uncorr     = $urandom_range(1);
      cap_syndrome   = 8'($urandom);
      cap_info       = 24'($urandom);
      cap_addr_valid = $urandom_range(1);
      cap_addr       = $urandom;
      wr_en          = ($urandom_range(2) == 0);
      wr_sel         = ($urandom_range(1) == 0) ? 2'd0 : 2'($urandom_range(3));
      wr_data        = $urandom;
    end
    @(negedge clk);
    cap_valid = 0; wr_en = 0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule